// File: doc/BRIEF.md
# Serial DAC Frame Writer

This block is a host-side master for a 16-bit voltage-output DAC that takes its commands over a three-wire serial link. The link has a frame strobe that is active low, a serial clock, and a data line. A client hands over a 16-bit code, a 2-bit power mode and a transfer-style flag with a valid/ready handshake. The block then assembles a 24-bit word and shifts it out from the system clock. The serial clock high and low phases and the strobe-high gap are each a whole number of system cycles. Elaboration rejects any setting that breaks the DAC's minimum timing for the chosen clock period and supply range.

The serial clock rests low. Each bit is presented on the line together with a rising edge, and the DAC samples it on the following falling edge. The strobe is parked low between transfers because that is the DAC's lowest-power state. It is raised for a fixed gap only at the start of each new frame, so every frame begins with a clean falling strobe. That also cancels any half-received word that a reset left in the DAC.

When the flag is set, the word goes out as three back-to-back byte transfers. A short pause with the clock low separates the bytes, and the strobe stays low throughout.

Top module: `sdw_writer`

## Requirements
- R1: While reset is applied and in the first cycle after it, dac_sync, dac_sclk, dac_sdata, busy and done are 0 and req_ready is 1.
- R2: A request is taken only in a cycle where req_valid and req_ready are both 1. From the next cycle until done, busy is 1 and req_ready is 0. Requests offered during that time are not taken and do not change the frame in flight.
- R3: Each frame carries exactly 24 falling edges of dac_sclk. The bits sampled on them, first to last, are six zeros, req_mode[1], req_mode[0], then req_code[15] down to req_code[0].
- R4: dac_sdata changes, while dac_sync is low, only in a cycle where dac_sclk rises. Its value is the same on both sides of every falling edge.
- R5: dac_sclk is low whenever no frame is in progress. Every high phase lasts exactly SCLK_HI_CYC cycles. In single-word transfers, every low phase that ends in a rising edge lasts exactly SCLK_LO_CYC cycles, including the lead-in after dac_sync falls.
- R6: dac_sync rests low when idle. Before each frame it is high for exactly SYNC_GAP_CYC cycles with dac_sclk low. It then stays low until the frame has ended.
- R7: done is a single-cycle pulse, given once per completed frame. It appears SYNC_GAP_CYC + SCLK_LO_CYC + 24*(SCLK_HI_CYC+SCLK_LO_CYC) cycles after the accepting edge, plus 2*BYTE_GAP_CYC when byte transfers are selected.
- R8: With req_bytes = 1, the low phase that follows the 8th falling edge and the one that follows the 16th each last SCLK_LO_CYC + BYTE_GAP_CYC cycles, and dac_sync stays low across both pauses.
- R9: A reset applied in the middle of a frame ends it with no done pulse. The next request produces a complete frame with a full strobe-high gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_code | input | 16 | DAC code to send |
| req_mode | input | 2 | Power mode bits placed ahead of the code |
| req_bytes | input | 1 | 1 = send as three byte transfers |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse when a frame has completed |
| dac_sync | output | 1 | Frame strobe, active low, parked low when idle |
| dac_sclk | output | 1 | Serial clock, rests low |
| dac_sdata | output | 1 | Serial data, valid across falling edges |

## Verification
The assertions take for granted that req_valid and the request fields are synchronous to clk, and that the fields are meaningful only in the accepting cycle. They check pulse widths, edge counts and data stability only after reset has been low for two cycles. The stimulus changes every input half a cycle away from the active edge. Requests offered during a frame carry inverted fields, so that any leakage into the frame would show up at the serial pins. The mid-frame reset is held for two full cycles and is released before the next request is offered.

// File: rtl/sdw_pkg.sv
`timescale 1ns/1ps
package sdw_pkg;

    // Word layout, most significant bit first on the wire
    localparam int SDW_PAD_W   = 6;
    localparam int SDW_MODE_W  = 2;
    localparam int SDW_CODE_W  = 16;
    localparam int SDW_FRAME_W = SDW_PAD_W + SDW_MODE_W + SDW_CODE_W;
    localparam int SDW_BYTE_W  = 8;
    localparam int SDW_FCNT_W  = $clog2(SDW_FRAME_W + 1);

    // Serial timing floors in picoseconds: fast = upper supply range, slow = lower
    localparam longint SDW_MIN_HIGH_PS     = 13000;
    localparam longint SDW_MIN_LOW_FAST_PS = 13000;
    localparam longint SDW_MIN_LOW_SLOW_PS = 22500;
    localparam longint SDW_MIN_PER_FAST_PS = 33000;
    localparam longint SDW_MIN_PER_SLOW_PS = 50000;
    localparam longint SDW_MIN_GAP_FAST_PS = 33000;
    localparam longint SDW_MIN_GAP_SLOW_PS = 50000;
    localparam longint SDW_MIN_SETUP_PS    = 5000;
    localparam longint SDW_MIN_HOLD_PS     = 4500;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_BGAP
    } sdw_state_e;

    typedef struct packed {
        logic                  bytes;
        logic [SDW_MODE_W-1:0] mode;
        logic [SDW_CODE_W-1:0] code;
    } sdw_req_t;

    function automatic bit span_ok(input int cyc, input int clk_ps, input longint min_ps);
        return (longint'(cyc) * longint'(clk_ps)) >= min_ps;
    endfunction

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    function automatic int cnt_width(input int max_len);
        return (max_len <= 2) ? 1 : $clog2(max_len);
    endfunction

endpackage

// File: rtl/sdw_phase_timer.sv
`timescale 1ns/1ps
module sdw_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/sdw_frame_shreg.sv
`timescale 1ns/1ps
module sdw_frame_shreg
    import sdw_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic                  shift,
    input  logic [SDW_MODE_W-1:0] mode,
    input  logic [SDW_CODE_W-1:0] code,
    output logic                  sdata
);

    logic [SDW_FRAME_W-1:0] word_q;
    logic [SDW_FRAME_W-1:0] word_ld;

    // Padding is driven as zeros ahead of the mode bits
    generate
        if (SDW_PAD_W > 0) begin : g_pad
            assign word_ld = {{SDW_PAD_W{1'b0}}, mode, code};
        end else begin : g_nopad
            assign word_ld = {mode, code};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (load) begin
            word_q <= word_ld;
        end else if (shift) begin
            word_q <= {word_q[SDW_FRAME_W-2:0], 1'b0};
        end
    end

    assign sdata = word_q[SDW_FRAME_W-1];

endmodule

// File: rtl/sdw_seq.sv
`timescale 1ns/1ps
module sdw_seq
    import sdw_pkg::*;
#(
    parameter int HI    = 3,
    parameter int LO    = 4,
    parameter int GAP   = 7,
    parameter int BG    = 2,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             start_bytes,
    input  logic             phase_last,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             shift,
    output logic             sync_o,
    output logic             sclk_o,
    output logic             done_o,
    output logic             idle_o
);

    localparam logic [CNT_W-1:0]      HI_V   = CNT_W'(HI - 1);
    localparam logic [CNT_W-1:0]      LO_V   = CNT_W'(LO - 1);
    localparam logic [CNT_W-1:0]      GAP_V  = CNT_W'(GAP - 1);
    localparam logic [CNT_W-1:0]      BG_V   = CNT_W'(BG - 1);
    localparam logic [SDW_FCNT_W-1:0] LAST_F = SDW_FCNT_W'(SDW_FRAME_W);
    localparam logic [SDW_FCNT_W-1:0] BYTE_F = SDW_FCNT_W'(SDW_BYTE_W);

    sdw_state_e            st_q, st_d;
    logic [SDW_FCNT_W-1:0] falls_q, falls_d;
    logic                  bytes_q;
    logic                  finish;
    logic                  at_byte_edge;
    logic                  sync_q, sclk_q, done_q;

    assign at_byte_edge = (falls_q != '0) && ((falls_q % BYTE_F) == '0);

    always_comb begin
        st_d     = st_q;
        falls_d  = falls_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        shift    = 1'b0;
        finish   = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (start) begin
                    st_d     = ST_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = GAP_V;
                    falls_d  = '0;
                end
            end
            ST_GAP: begin
                if (phase_last) begin
                    st_d     = ST_LEAD;
                    tmr_load = 1'b1;
                    tmr_val  = LO_V;
                end
            end
            ST_LEAD: begin
                if (phase_last) begin
                    st_d     = ST_HIGH;
                    tmr_load = 1'b1;
                    tmr_val  = HI_V;
                end
            end
            ST_HIGH: begin
                if (phase_last) begin
                    st_d     = ST_LOW;
                    tmr_load = 1'b1;
                    tmr_val  = LO_V;
                    falls_d  = falls_q + 1'b1;
                end
            end
            ST_LOW: begin
                if (phase_last) begin
                    if (falls_q == LAST_F) begin
                        st_d   = ST_IDLE;
                        finish = 1'b1;
                    end else if (bytes_q && at_byte_edge) begin
                        st_d     = ST_BGAP;
                        tmr_load = 1'b1;
                        tmr_val  = BG_V;
                    end else begin
                        st_d     = ST_HIGH;
                        tmr_load = 1'b1;
                        tmr_val  = HI_V;
                        shift    = 1'b1;
                    end
                end
            end
            ST_BGAP: begin
                if (phase_last) begin
                    st_d     = ST_HIGH;
                    tmr_load = 1'b1;
                    tmr_val  = HI_V;
                    shift    = 1'b1;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            falls_q <= '0;
            bytes_q <= 1'b0;
            sync_q  <= 1'b0;
            sclk_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            st_q    <= st_d;
            falls_q <= falls_d;
            if (st_q == ST_IDLE && start) begin
                bytes_q <= start_bytes;
            end
            // pins come straight from flops, decoded from the next state
            sync_q  <= (st_d == ST_GAP);
            sclk_q  <= (st_d == ST_HIGH);
            done_q  <= finish;
        end
    end

    assign sync_o = sync_q;
    assign sclk_o = sclk_q;
    assign done_o = done_q;
    assign idle_o = (st_q == ST_IDLE);

endmodule

// File: rtl/sdw_writer.sv
`timescale 1ns/1ps
module sdw_writer
    import sdw_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 8000,
    parameter bit LOW_SUPPLY    = 1'b1,
    parameter int SCLK_HI_CYC   = 3,
    parameter int SCLK_LO_CYC   = 4,
    parameter int SYNC_GAP_CYC  = 7,
    parameter int BYTE_GAP_CYC  = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [SDW_CODE_W-1:0] req_code,
    input  logic [SDW_MODE_W-1:0] req_mode,
    input  logic                  req_bytes,
    output logic                  busy,
    output logic                  done,
    output logic                  dac_sync,
    output logic                  dac_sclk,
    output logic                  dac_sdata
);

    localparam int MAX_LEN = max4(SCLK_HI_CYC, SCLK_LO_CYC, SYNC_GAP_CYC, BYTE_GAP_CYC);
    localparam int CNT_W   = cnt_width(MAX_LEN);

    localparam longint LOW_MIN = LOW_SUPPLY ? SDW_MIN_LOW_SLOW_PS : SDW_MIN_LOW_FAST_PS;
    localparam longint PER_MIN = LOW_SUPPLY ? SDW_MIN_PER_SLOW_PS : SDW_MIN_PER_FAST_PS;
    localparam longint GAP_MIN = LOW_SUPPLY ? SDW_MIN_GAP_SLOW_PS : SDW_MIN_GAP_FAST_PS;

    localparam bit LEN_OK  = (SCLK_HI_CYC >= 1) && (SCLK_LO_CYC >= 1) &&
                             (SYNC_GAP_CYC >= 1) && (BYTE_GAP_CYC >= 1) &&
                             ((SDW_FRAME_W % SDW_BYTE_W) == 0);
    localparam bit HIGH_OK = span_ok(SCLK_HI_CYC, CLK_PERIOD_PS, SDW_MIN_HIGH_PS) &&
                             span_ok(SCLK_HI_CYC, CLK_PERIOD_PS, SDW_MIN_SETUP_PS);
    localparam bit LOW_OK  = span_ok(SCLK_LO_CYC, CLK_PERIOD_PS, LOW_MIN) &&
                             span_ok(SCLK_LO_CYC, CLK_PERIOD_PS, SDW_MIN_HOLD_PS);
    localparam bit PER_OK  = span_ok(SCLK_HI_CYC + SCLK_LO_CYC, CLK_PERIOD_PS, PER_MIN);
    localparam bit GAP_OK  = span_ok(SYNC_GAP_CYC, CLK_PERIOD_PS, GAP_MIN);

    generate
        if (!LEN_OK) begin : g_bad_len
            $error("sdw_writer: phase lengths must be at least one cycle");
        end
        if (!HIGH_OK) begin : g_bad_high
            $error("sdw_writer: serial clock high phase too short for this clock");
        end
        if (!LOW_OK) begin : g_bad_low
            $error("sdw_writer: serial clock low phase too short for this clock");
        end
        if (!PER_OK) begin : g_bad_period
            $error("sdw_writer: serial clock period too short for this supply range");
        end
        if (!GAP_OK) begin : g_bad_gap
            $error("sdw_writer: strobe-high gap too short for this supply range");
        end
    endgenerate

    sdw_req_t         req_in;
    logic             idle;
    logic             start;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             phase_last;
    logic             shift;

    assign req_in = '{bytes: req_bytes, mode: req_mode, code: req_code};
    assign start  = req_valid && idle;

    sdw_phase_timer #(
        .CNT_W (CNT_W)
    ) timer_i (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (phase_last)
    );

    sdw_frame_shreg shreg_i (
        .clk   (clk),
        .rst   (rst),
        .load  (start),
        .shift (shift),
        .mode  (req_in.mode),
        .code  (req_in.code),
        .sdata (dac_sdata)
    );

    sdw_seq #(
        .HI    (SCLK_HI_CYC),
        .LO    (SCLK_LO_CYC),
        .GAP   (SYNC_GAP_CYC),
        .BG    (BYTE_GAP_CYC),
        .CNT_W (CNT_W)
    ) seq_i (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .start_bytes (req_in.bytes),
        .phase_last  (phase_last),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .shift       (shift),
        .sync_o      (dac_sync),
        .sclk_o      (dac_sclk),
        .done_o      (done),
        .idle_o      (idle)
    );

    assign req_ready = idle;
    assign busy      = !idle;

endmodule

// File: rtl/sdw_writer_chk.sv
`timescale 1ns/1ps
module sdw_writer_chk
    import sdw_pkg::*;
#(
    parameter int HI  = 3,
    parameter int GAP = 7
) (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_ready,
    input logic busy,
    input logic done,
    input logic dac_sync,
    input logic dac_sclk,
    input logic dac_sdata
);

    localparam int RUN_W = 16;

    logic [RUN_W-1:0]      hi_run_q, gap_run_q;
    logic [SDW_FCNT_W-1:0] falls_q;
    logic                  sclk_d, rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            hi_run_q  <= '0;
            gap_run_q <= '0;
            falls_q   <= '0;
            sclk_d    <= 1'b0;
        end else begin
            sclk_d    <= dac_sclk;
            hi_run_q  <= dac_sclk ? hi_run_q + 1'b1 : '0;
            gap_run_q <= dac_sync ? gap_run_q + 1'b1 : '0;
            if (dac_sync) begin
                falls_q <= '0;
            end else if (sclk_d && !dac_sclk) begin
                falls_q <= falls_q + 1'b1;
            end
        end
    end

    // R1: one cycle after a reset edge the pins are parked
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (!dac_sync && !dac_sclk && !dac_sdata && !busy && !done && req_ready));

    // R2: ready and busy are mutually exclusive
    p_no_accept_busy_r2: assert property (@(posedge clk) disable iff (rst || rst_q)
        busy |-> !req_ready);

    // R2: a taken request makes the block busy next cycle
    p_accept_busy_r2: assert property (@(posedge clk) disable iff (rst || rst_q)
        (req_valid && req_ready) |=> busy);

    // R3: a completed frame carries the full count of falling edges
    p_frame_falls_r3: assert property (@(posedge clk) disable iff (rst || rst_q)
        done |-> (falls_q == SDW_FCNT_W'(SDW_FRAME_W)));

    // R4: data is unchanged across a falling edge
    p_data_stable_r4: assert property (@(posedge clk) disable iff (rst || rst_q)
        $fell(dac_sclk) |-> $stable(dac_sdata));

    // R5: every high phase has the configured length
    p_high_len_r5: assert property (@(posedge clk) disable iff (rst || rst_q)
        $fell(dac_sclk) |-> (hi_run_q == RUN_W'(HI)));

    // R6: clock never high while the strobe is high
    p_sclk_quiet_r6: assert property (@(posedge clk) disable iff (rst || rst_q)
        dac_sync |-> !dac_sclk);

    // R6: strobe-high gap has the configured length
    p_gap_len_r6: assert property (@(posedge clk) disable iff (rst || rst_q)
        $fell(dac_sync) |-> (gap_run_q == RUN_W'(GAP)));

    // R7: done lasts one cycle
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst || rst_q)
        done |=> !done);

endmodule

bind sdw_writer sdw_writer_chk #(
    .HI  (SCLK_HI_CYC),
    .GAP (SYNC_GAP_CYC)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .busy      (busy),
    .done      (done),
    .dac_sync  (dac_sync),
    .dac_sclk  (dac_sclk),
    .dac_sdata (dac_sdata)
);

// File: tb/sdw_writer_tb_top.sv
`timescale 1ns/1ps
module sdw_writer_tb_top;

    localparam int HI  = 3;
    localparam int LO  = 4;
    localparam int GAP = 7;
    localparam int BG  = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_code = '0;
    logic [1:0]  req_mode = '0;
    logic        req_bytes = 1'b0;
    logic        busy, done, dac_sync, dac_sclk, dac_sdata;

    int          n_chk = 0;
    int          n_err = 0;
    int          cyc = 0;
    int          acc_cyc = 0;
    int          frames_done = 0;
    int          frames_good = 0;
    bit          pending = 0;
    bit          finished = 0;
    logic [23:0] exp_frame = '0;
    bit          exp_bytes = 0;

    // monitor state
    logic [23:0] cap = '0;
    int          nfall = 0, hi_run = 0, lo_run = 0, sync_run = 0;
    logic        p_sclk = 0, p_data = 0, p_sync = 0, p_done = 0;

    always #4 clk = ~clk;

    sdw_writer #(
        .CLK_PERIOD_PS (8000),
        .LOW_SUPPLY    (1'b1),
        .SCLK_HI_CYC   (HI),
        .SCLK_LO_CYC   (LO),
        .SYNC_GAP_CYC  (GAP),
        .BYTE_GAP_CYC  (BG)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_code  (req_code),
        .req_mode  (req_mode),
        .req_bytes (req_bytes),
        .busy      (busy),
        .done      (done),
        .dac_sync  (dac_sync),
        .dac_sclk  (dac_sclk),
        .dac_sdata (dac_sdata)
    );

    function automatic logic [23:0] mk_frame(input logic [15:0] c, input logic [1:0] m);
        return {6'b000000, m[1], m[0], c};
    endfunction

    function automatic int frame_cycles(input bit b);
        return GAP + LO + 24 * (HI + LO) + (b ? 2 * BG : 0);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_parked(input string tag);
        chk(!dac_sync && !dac_sclk && !dac_sdata && !busy && !done && req_ready, tag,
            {26'd0, dac_sync, dac_sclk, dac_sdata, busy, done, req_ready}, 32'h1);
    endtask

    // Serial-side model of the DAC input: sampled half a cycle after each active edge
    always @(negedge clk) begin
        int extra;
        #1;
        cyc++;
        if (rst) begin
            nfall = 0; cap = '0; hi_run = 0; lo_run = 0; sync_run = 0;
        end else begin
            if (dac_sync) begin
                chk(!dac_sclk, "R6 sclk low while strobe high", dac_sclk, 0);
                sync_run++; nfall = 0; cap = '0; lo_run = 0; hi_run = 0;
            end else begin
                if (p_sync) chk(sync_run == GAP, "R6 strobe gap length", sync_run, GAP);
                sync_run = 0;
                if (dac_sclk) begin
                    if (!p_sclk) begin
                        extra = (exp_bytes && nfall != 0 && nfall % 8 == 0 && nfall < 24) ? BG : 0;
                        if (extra != 0)
                            chk(lo_run == LO + extra, "R8 byte pause length", lo_run, LO + extra);
                        else
                            chk(lo_run == LO, "R5 low phase length", lo_run, LO);
                        lo_run = 0;
                    end
                    hi_run++;
                end else begin
                    if (p_sclk) begin
                        chk(hi_run == HI, "R5 high phase length", hi_run, HI);
                        chk(dac_sdata == p_data, "R4 data stable across fall", dac_sdata, p_data);
                        cap = {cap[22:0], dac_sdata};
                        nfall++;
                        hi_run = 0;
                    end
                    lo_run++;
                end
                if (!p_sync && dac_sdata != p_data)
                    chk(dac_sclk && !p_sclk, "R4 data moved away from rising edge", dac_sclk, 1);
            end
            if (done) begin
                chk(pending, "R7 done only for a taken frame", pending, 1);
                chk(nfall == 24, "R3 falling edge count", nfall, 24);
                chk(cap == exp_frame, "R3 frame bits", cap, exp_frame);
                chk(cyc - acc_cyc == frame_cycles(exp_bytes) + 1, "R7 done latency",
                    cyc - acc_cyc, frame_cycles(exp_bytes) + 1);
                chk(req_ready && !busy, "R2 idle when done", {busy, req_ready}, 2'b01);
                frames_done++;
                pending = 0;
            end
            if (p_done) chk(!done, "R7 done single pulse", done, 0);
            if (!busy && !dac_sync) chk(!dac_sclk, "R5 clock rests low", dac_sclk, 0);
        end
        p_sclk = dac_sclk; p_data = dac_sdata; p_sync = dac_sync; p_done = done;
    end

    task automatic send(input logic [15:0] c, input logic [1:0] m, input bit b,
                        input bit junk, input bit wait_done);
        @(negedge clk);
        chk(req_ready === 1'b1, "R2 ready before request", req_ready, 1);
        req_valid = 1'b1; req_code = c; req_mode = m; req_bytes = b;
        @(posedge clk);
        exp_frame = mk_frame(c, m);
        exp_bytes = b;
        acc_cyc   = cyc;
        pending   = 1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy && !req_ready, "R2 busy after accept", {busy, req_ready}, 2'b10);
        if (junk) begin
            for (int k = 0; k < 5; k++) begin
                req_valid = 1'b1; req_code = ~c; req_mode = ~m; req_bytes = ~b;
                @(negedge clk);
                chk(!req_ready, "R2 request held off while busy", req_ready, 0);
            end
            req_valid = 1'b0;
        end
        if (wait_done) begin
            while (pending) @(negedge clk);
            frames_good++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL R7 watchdog expired actual=%0d expected=%0d", frames_done, frames_good);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00c0ffee));
        repeat (4) @(negedge clk);
        check_parked("R1 outputs during reset");
        rst = 1'b0;
        @(negedge clk);
        check_parked("R1 outputs after reset");

        // directed corners
        send(16'h0000, 2'b00, 1'b0, 1'b0, 1'b1);
        send(16'hFFFF, 2'b11, 1'b1, 1'b1, 1'b1);
        send(16'h8001, 2'b10, 1'b0, 1'b1, 1'b1);
        send(16'h5A5A, 2'b01, 1'b1, 1'b0, 1'b1);
        @(negedge clk);
        chk(!dac_sync && !dac_sclk, "R6 strobe parked low when idle", {dac_sync, dac_sclk}, 0);

        // reset in the middle of a frame
        send(16'h1234, 2'b11, 1'b0, 1'b0, 1'b0);
        repeat (60) @(negedge clk);
        rst = 1'b1;
        pending = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_parked("R9 parked after mid-frame reset");
        send(16'hA5C3, 2'b10, 1'b1, 1'b0, 1'b1);
        chk(frames_done == frames_good, "R9 frame after reset", frames_done, frames_good);

        // constrained random traffic
        for (int i = 0; i < 24; i++) begin
            logic [15:0] c;
            logic [1:0]  m;
            bit          b;
            c = 16'($urandom);
            m = 2'($urandom % 4);
            b = 1'($urandom % 2);
            send(c, m, b, (i % 3) == 0, 1'b1);
            repeat ($urandom % 4) @(negedge clk);
        end

        repeat (4) @(negedge clk);
        chk(frames_done == frames_good, "R2 one done per taken request", frames_done, frames_good);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule